// File: doc/BRIEF.md
# Conditional Select-Increment Execute Stage

This block is the execute step for an integer instruction that picks between two register values under a flag condition. When the condition holds, the result is the first source operand. When it fails, the result is the second source operand plus one. The stage also recognises the conditional-increment shorthand. That form names one source register in both source fields and stores the user condition with its lowest bit flipped, so the result is "source + 1 if the user condition holds, else source". The stage raises a dedicated flag whenever the word has that shorthand form.

Each cycle the surrounding pipeline presents three things: a 32-bit instruction word, the two operand values already fetched for the source fields, and the current N/Z/C/V flags. One clock edge later the stage returns the destination index, the result, a write enable and the shorthand flag. Every word takes the same fixed path, whatever the data or flag values. Words that do not carry the instruction's fixed opcode bits produce no write.

Top module: `csi_exec`

## Requirements
- R1: A word is accepted only when bits 30..21 equal 0011010100 and bits 11..10 equal 01. Any other word gives a write enable of 0, a result of 0, a destination of 0 and a shorthand flag of 0.
- R2: The fields sit at these positions: destination index in bits 4..0, first source index in bits 9..5, condition in bits 15..12, second source index in bits 20..16. For an accepted word, `rd_o` returns bits 4..0.
- R3: If the condition evaluates true, the result is the first operand. Otherwise it is the second operand plus one.
- R4: The flag input is ordered N=bit 3, Z=bit 2, C=bit 1, V=bit 0. Condition bits 3..1 select the base test: 000 Z, 001 C, 010 N, 011 V, 100 C and not Z, 101 N equals V, 110 not Z and N equals V, 111 always true.
- R5: A condition with bit 0 set inverts the base test, except for 1111. Both 1110 and 1111 always evaluate true.
- R6: When bit 31 is 0, the operation uses the low 32 bits of each operand. The sum wraps modulo 2^32 and the result is zero-extended to 64 bits. When bit 31 is 1, the operation is full 64-bit and wraps modulo 2^64.
- R7: A source index of 11111 reads as zero, and the operand value on the port is ignored.
- R8: A destination index of 11111 forces the write enable to 0.
- R9: The shorthand flag is 1 only for an accepted word with both source indices equal, the source index not 11111, and condition bits 3..1 not 111.
- R10: All outputs are registered. Each word's outputs appear exactly one clock after it is presented, whatever the data or flags. A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 64 | Value read for the first source index (bits 9..5) |
| src_b_i | input | 64 | Value read for the second source index (bits 20..16) |
| nzcv_i | input | 4 | Flags, N at bit 3 down to V at bit 0 |
| rd_o | output | 5 | Destination index |
| result_o | output | 64 | Result value |
| wr_en_o | output | 1 | Destination write enable |
| inc_alias_o | output | 1 | Word has the conditional-increment shorthand form |

## Verification
The main function is driven with all sixteen condition codes against all sixteen flag combinations. Distinct first and second operands show which path was taken, and that separates each base test from its inverted twin as well as from the two always-true codes. Operand values close to all ones in both widths, with junk in the upper half during 32-bit operation, show where the carry wraps and whether zero-extension happens. Directed words with the zero-register index in each field, equal and unequal source indices, always-true conditions and corrupted opcode bits separate the write-suppress rules from the shorthand-detect rule. A long random run then mixes all of these.

// File: rtl/csi_pkg.sv
package csi_pkg;

  // Fixed instruction layout of the select-increment family
  localparam int unsigned INSN_W   = 32;
  localparam int unsigned IDX_W    = 5;
  localparam int unsigned COND_W   = 4;
  localparam int unsigned FLAG_W   = 4;
  localparam logic [9:0]  OPC_HI   = 10'b0011010100;
  localparam logic [1:0]  OPC_LO   = 2'b01;
  localparam logic [IDX_W-1:0] ZERO_IDX = '1;

  // Flag positions inside the flag vector
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_C = 1;
  localparam int unsigned FLG_V = 0;

  typedef enum logic [2:0] {
    BT_ZERO   = 3'b000,
    BT_CARRY  = 3'b001,
    BT_NEG    = 3'b010,
    BT_OVF    = 3'b011,
    BT_ABOVE  = 3'b100,
    BT_SGE    = 3'b101,
    BT_SGT    = 3'b110,
    BT_ALWAYS = 3'b111
  } base_test_e;

  typedef struct packed {
    logic              wide;
    logic [IDX_W-1:0]  src_b;
    logic [COND_W-1:0] cond;
    logic [IDX_W-1:0]  src_a;
    logic [IDX_W-1:0]  dst;
  } insn_fields_t;

endpackage

// File: rtl/csi_decode.sv
module csi_decode
  import csi_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output insn_fields_t      fld,
  output logic              match,
  output logic              dst_live,
  output logic [1:0]        src_is_zero,
  output logic              alias_hit
);

  always_comb begin
    fld.wide  = insn[31];
    fld.src_b = insn[20:16];
    fld.cond  = insn[15:12];
    fld.src_a = insn[9:5];
    fld.dst   = insn[4:0];
  end

  assign match = (insn[30:21] == OPC_HI) && (insn[11:10] == OPC_LO);

  assign dst_live       = (fld.dst != ZERO_IDX);
  assign src_is_zero[0] = (fld.src_a == ZERO_IDX);
  assign src_is_zero[1] = (fld.src_b == ZERO_IDX);

  // Shorthand form: one real source named twice, condition not always/never
  assign alias_hit = match
                   && (fld.src_a == fld.src_b)
                   && !src_is_zero[0]
                   && (fld.cond[3:1] != 3'b111);

endmodule

// File: rtl/csi_cond_eval.sv
module csi_cond_eval
  import csi_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);

  logic       f_n, f_z, f_c, f_v;
  logic       base;
  base_test_e sel;

  assign f_n = flags[FLG_N];
  assign f_z = flags[FLG_Z];
  assign f_c = flags[FLG_C];
  assign f_v = flags[FLG_V];
  assign sel = base_test_e'(cond[3:1]);

  always_comb begin
    unique case (sel)
      BT_ZERO:   base = f_z;
      BT_CARRY:  base = f_c;
      BT_NEG:    base = f_n;
      BT_OVF:    base = f_v;
      BT_ABOVE:  base = f_c & ~f_z;
      BT_SGE:    base = (f_n == f_v);
      BT_SGT:    base = ~f_z & (f_n == f_v);
      default:   base = 1'b1;
    endcase
  end

  // Low bit inverts, except the all-ones code which stays always-true
  assign pass = (cond[0] && (cond != '1)) ? ~base : base;

endmodule

// File: rtl/csi_datapath.sv
module csi_datapath #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input  logic                 wide,
  input  logic [1:0]           src_zero,
  input  logic [1:0][XLEN-1:0] src,
  input  logic                 pass,
  output logic [XLEN-1:0]      res
);

  localparam int unsigned PAD = XLEN - NARROW;

  logic [1:0][XLEN-1:0] opnd;
  logic [XLEN-1:0]      bumped;
  logic [XLEN-1:0]      picked;

  // Zero-register gating, one per source
  for (genvar g = 0; g < 2; g++) begin : g_opnd
    assign opnd[g] = src_zero[g] ? '0 : src[g];
  end

  // Both candidates are always formed; selection is a plain mux
  assign bumped = opnd[1] + XLEN'(1);
  assign picked = pass ? opnd[0] : bumped;

  if (PAD > 0) begin : g_narrow
    assign res = wide ? picked : {{PAD{1'b0}}, picked[NARROW-1:0]};
  end else begin : g_full
    logic unused_wide;
    assign unused_wide = wide;
    assign res = picked;
  end

endmodule

// File: rtl/csi_exec.sv
module csi_exec
  import csi_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       insn_i,
  input  logic [XLEN-1:0]   src_a_i,
  input  logic [XLEN-1:0]   src_b_i,
  input  logic [3:0]        nzcv_i,
  output logic [4:0]        rd_o,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic              inc_alias_o
);

  insn_fields_t         fld;
  logic                 match, dst_live, alias_hit, pass;
  logic [1:0]           src_is_zero;
  logic [1:0][XLEN-1:0] src;
  logic [XLEN-1:0]      res;

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;

  csi_decode u_dec (
    .insn        (insn_i),
    .fld         (fld),
    .match       (match),
    .dst_live    (dst_live),
    .src_is_zero (src_is_zero),
    .alias_hit   (alias_hit)
  );

  csi_cond_eval u_cond (
    .cond  (fld.cond),
    .flags (nzcv_i),
    .pass  (pass)
  );

  csi_datapath #(.XLEN(XLEN), .NARROW(NARROW)) u_dp (
    .wide     (fld.wide),
    .src_zero (src_is_zero),
    .src      (src),
    .pass     (pass),
    .res      (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_o        <= '0;
      result_o    <= '0;
      wr_en_o     <= 1'b0;
      inc_alias_o <= 1'b0;
    end else begin
      rd_o        <= match ? fld.dst : '0;
      result_o    <= match ? res : '0;
      wr_en_o     <= match && dst_live;
      inc_alias_o <= alias_hit;
    end
  end

endmodule

// File: rtl/csi_exec_chk.sv
module csi_exec_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [31:0]     insn_i,
  input logic [4:0]      rd_o,
  input logic [XLEN-1:0] result_o,
  input logic            wr_en_o,
  input logic            inc_alias_o
);

  logic opc_ok;
  assign opc_ok = (insn_i[30:21] == 10'b0011010100) && (insn_i[11:10] == 2'b01);

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_en_o && !inc_alias_o && result_o == '0 && rd_o == '0));

  p_bad_opcode_r1: assert property (@(posedge clk) disable iff (rst)
    !opc_ok |=> (!wr_en_o && !inc_alias_o && result_o == '0));

  p_zero_dst_r8: assert property (@(posedge clk) disable iff (rst)
    (insn_i[4:0] == 5'h1F) |=> !wr_en_o);

  p_narrow_ext_r6: assert property (@(posedge clk) disable iff (rst)
    !insn_i[31] |=> (result_o[XLEN-1:NARROW] == '0));

  p_alias_split_r9: assert property (@(posedge clk) disable iff (rst)
    (insn_i[9:5] != insn_i[20:16]) |=> !inc_alias_o);

  p_alias_no_al_r9: assert property (@(posedge clk) disable iff (rst)
    (insn_i[15:13] == 3'b111) |=> !inc_alias_o);

  p_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    (opc_ok && insn_i[4:0] != 5'h1F) |=> (wr_en_o && rd_o == $past(insn_i[4:0])));

endmodule

bind csi_exec csi_exec_chk #(.XLEN(XLEN), .NARROW(NARROW)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .insn_i      (insn_i),
  .rd_o        (rd_o),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .inc_alias_o (inc_alias_o)
);

// File: tb/test_csi_exec.sv
module test_csi_exec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_i = '0;
  logic [63:0] src_a_i = '0;
  logic [63:0] src_b_i = '0;
  logic [3:0]  nzcv_i = '0;
  logic [4:0]  rd_o;
  logic [63:0] result_o;
  logic        wr_en_o;
  logic        inc_alias_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  csi_exec i_csi_exec (
    .clk(clk), .rst(rst), .insn_i(insn_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .nzcv_i(nzcv_i), .rd_o(rd_o), .result_o(result_o), .wr_en_o(wr_en_o),
    .inc_alias_o(inc_alias_o)
  );

  typedef struct {
    logic [4:0]  rd;
    logic [63:0] res;
    logic        we;
    logic        al;
    string       tag;
  } exp_t;

  exp_t sb[$];

  function automatic logic [31:0] mk(input logic sf, input logic [4:0] rm,
                                     input logic [3:0] cond, input logic [4:0] rn,
                                     input logic [4:0] rd);
    return {sf, 10'b0011010100, rm, cond, 2'b01, rn, rd};
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] a,
                                 input logic [63:0] b, input logic [3:0] f, input string tag);
    exp_t e;
    logic ok, t, nn, zz, cc, vv;
    logic [63:0] x, y, r;
    ok = (w[30:21] == 10'b0011010100) && (w[11:10] == 2'b01);
    nn = f[3]; zz = f[2]; cc = f[1]; vv = f[0];
    x = (w[9:5] == 5'd31) ? 64'd0 : a;
    y = (w[20:16] == 5'd31) ? 64'd0 : b;
    case (w[15:13])
      3'd0: t = zz;
      3'd1: t = cc;
      3'd2: t = nn;
      3'd3: t = vv;
      3'd4: t = cc && !zz;
      3'd5: t = (nn == vv);
      3'd6: t = !zz && (nn == vv);
      default: t = 1'b1;
    endcase
    if (w[12] && w[15:12] != 4'hF) t = !t;
    if (!w[31]) begin
      x = {32'd0, x[31:0]};
      y = {32'd0, y[31:0]};
    end
    r = t ? x : y + 64'd1;
    if (!w[31]) r = {32'd0, r[31:0]};
    e.rd  = ok ? w[4:0] : 5'd0;
    e.res = ok ? r : 64'd0;
    e.we  = ok && (w[4:0] != 5'd31);
    e.al  = ok && (w[9:5] == w[20:16]) && (w[9:5] != 5'd31) && (w[15:13] != 3'b111);
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] f, input string tag);
    @(negedge clk);
    insn_i = w; src_a_i = a; src_b_i = b; nzcv_i = f;
    sb.push_back(model(w, a, b, f, tag));
  endtask

  // Monitor: an item pushed at a falling edge is registered at the next rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_o !== e.rd || result_o !== e.res || wr_en_o !== e.we || inc_alias_o !== e.al) begin
        errors++;
        $display("FAIL %s: got rd=%0d res=%h we=%0b al=%0b exp rd=%0d res=%h we=%0b al=%0b",
                 e.tag, rd_o, result_o, wr_en_o, inc_alias_o, e.rd, e.res, e.we, e.al);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] w;
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (rd_o !== 0 || result_o !== 0 || wr_en_o !== 0 || inc_alias_o !== 0) begin
      errors++;
      $display("FAIL R10 reset: got rd=%0d res=%h we=%0b al=%0b exp all zero",
               rd_o, result_o, wr_en_o, inc_alias_o);
    end
    insn_i = mk(1'b1, 5'd2, 4'h0, 5'd1, 5'd3);
    rst = 1'b0;

    // R4 R5 R3: every condition against every flag pattern
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        drive(mk(1'b1, 5'd7, 4'(c), 5'd6, 5'd1), 64'h1111_2222_3333_4444,
              64'h0000_0000_0000_0100, 4'(f), "R4_R5_R3 cond");

    // R6 width and wrap
    drive(mk(1'b0, 5'd2, 4'h0, 5'd1, 5'd4), 64'hAAAA_0000_0000_0005, 64'hDEAD_BEEF_FFFF_FFFF, 4'h0, "R6 wrap32");
    drive(mk(1'b0, 5'd2, 4'h0, 5'd1, 5'd4), 64'hAAAA_BBBB_1234_5678, 64'h0, 4'h4, "R6 zext32");
    drive(mk(1'b1, 5'd2, 4'h0, 5'd1, 5'd4), 64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0, "R6 wrap64");
    drive(mk(1'b1, 5'd2, 4'h0, 5'd1, 5'd4), 64'h5, 64'h0000_0000_FFFF_FFFF, 4'h0, "R6 carry64");
    // R7 zero-register sources
    drive(mk(1'b1, 5'd31, 4'h0, 5'd1, 5'd4), 64'h5, 64'h1234, 4'h0, "R7 rm zero");
    drive(mk(1'b1, 5'd2, 4'h0, 5'd31, 5'd4), 64'h5, 64'h1234, 4'h4, "R7 rn zero");
    // R8 zero-register destination
    drive(mk(1'b1, 5'd2, 4'h0, 5'd1, 5'd31), 64'h5, 64'h9, 4'h4, "R8 rd zero");
    // R9 shorthand detection
    drive(mk(1'b1, 5'd9, 4'h1, 5'd9, 5'd4), 64'h77, 64'h77, 4'h4, "R9 alias");
    drive(mk(1'b0, 5'd9, 4'hE, 5'd9, 5'd4), 64'h77, 64'h77, 4'h0, "R9 no alias AL");
    drive(mk(1'b0, 5'd9, 4'hF, 5'd9, 5'd4), 64'h77, 64'h77, 4'h0, "R9 no alias NV");
    drive(mk(1'b1, 5'd31, 4'h0, 5'd31, 5'd4), 64'h77, 64'h77, 4'h0, "R9 no alias zr");
    drive(mk(1'b1, 5'd8, 4'h0, 5'd9, 5'd4), 64'h77, 64'h77, 4'h0, "R9 no alias split");
    // R1 opcode mismatch, R2 field placement
    w = mk(1'b1, 5'd9, 4'h0, 5'd9, 5'd4); w[25] = ~w[25];
    drive(w, 64'h77, 64'h77, 4'h0, "R1 bad hi");
    w = mk(1'b1, 5'd9, 4'h0, 5'd9, 5'd4); w[10] = 1'b0;
    drive(w, 64'h77, 64'h77, 4'h0, "R1 bad lo");
    drive(mk(1'b1, 5'd17, 4'h6, 5'd10, 5'd21), 64'h3, 64'h8, 4'hF, "R2 fields");

    // R10 back-to-back random mix
    for (int i = 0; i < 400; i++) begin
      w = $urandom;
      if (i % 4 != 0) begin
        w[30:21] = 10'b0011010100;
        w[11:10] = 2'b01;
      end
      if (i % 7 == 0) w[20:16] = w[9:5];
      drive(w, {$urandom, $urandom}, {$urandom, $urandom}, 4'($urandom), "R10 random");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule